// File: doc/BRIEF.md
# Instruction Prefetch Queue with Branch-Target Fetch

This unit sits between a 16-bit processor core and its memory bus. It keeps a 16-byte queue filled with instruction bytes while the core decodes and executes, so fetching overlaps execution. The core takes bytes one at a time from the head of the queue. It stalls whenever the queue reports no valid byte.

When the decoder sees a conditional branch, it raises a hint with the branch destination. The unit then issues one word fetch of that destination before sequential fetching continues. It does this whether or not the branch is later taken. The returned word never enters the queue, and the sequential fetch address is left untouched.

A taken branch, or any other change of flow, is signalled by a flush with a new 20-bit address. The flush empties the queue and restarts fetching from that address.

Top module: `pfq_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `pop_valid` is 0, `mem_req` is 1 and `mem_addr` equals `RESET_ADDR` with bit 0 cleared.
- R2: With no target fetch pending, `mem_req` is 1 exactly when at least 2 of the 16 byte slots are free. `mem_addr` is then the fetch pointer with bit 0 cleared.
- R3: A transfer is a cycle with `mem_req` and `mem_ack` both high. A sequential transfer from an even fetch pointer appends `mem_rdata[7:0]` and then `mem_rdata[15:8]` to the queue, and advances the pointer by 2.
- R4: A sequential transfer from an odd fetch pointer appends only `mem_rdata[15:8]` and advances the pointer by 1, which realigns it to even.
- R5: `pop_valid` is 1 exactly when the queue holds a byte. `pop_byte` is the oldest byte, and it is removed in a cycle with `pop_valid` and `pop_ready` both high.
- R6: A request that is not acknowledged stays asserted with the same address in the next cycle, unless a flush or branch hint arrived in that cycle.
- R7: A branch hint makes the next request fetch `br_target` with bit 0 cleared, even when the queue is full. That fetch is issued once. Its data is dropped, the fetch pointer is unchanged, and sequential requests resume after it.
- R8: A new hint arriving before the pending target fetch completes replaces its address. Only one target fetch results.
- R9: A flush empties the queue, loads the fetch pointer from `flush_addr` and cancels any pending target fetch. A transfer, pop or hint in the same cycle has no effect.
- R10: The queue never holds more than 16 bytes. When it is full and no target fetch is pending, `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Change of flow: restart fetching from `flush_addr` |
| flush_addr | input | 20 | New byte address for fetching |
| br_hint | input | 1 | Conditional branch decoded; fetch its target once |
| br_target | input | 20 | Destination byte address of the decoded branch |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | 20 | Word-aligned byte address of the request |
| mem_ack | input | 1 | Request accepted; `mem_rdata` valid this cycle |
| mem_rdata | input | 16 | Fetched word, lower address in the low byte |
| pop_valid | output | 1 | Queue head holds a byte |
| pop_byte | output | 8 | Oldest queued byte |
| pop_ready | input | 1 | Core takes the head byte this cycle |

## Verification
The assertions assume that memory returns data in the same cycle it acknowledges and that `mem_ack` matters only while a request is up. They also assume the core never takes a byte that is not offered. The stimulus meets these assumptions in the following ways. A combinational memory model derives `mem_rdata` from `mem_addr` alone. `pop_ready` is treated as a plain willingness flag. Flushes and hints arrive at arbitrary points, including the same cycle as transfers, pops and each other, and with the queue full or empty.

// File: rtl/pfq_unit.sv
module pfq_unit #(
  parameter int          AW         = 20,
  parameter int          QBYTES     = 16,
  parameter logic [19:0] RESET_ADDR = 20'hFFFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          br_hint,
  input  logic [AW-1:0] br_target,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [15:0]   mem_rdata,
  output logic          pop_valid,
  output logic [7:0]    pop_byte,
  input  logic          pop_ready
);
  localparam int CW = $clog2(QBYTES + 1);
  localparam int PW = $clog2(QBYTES);

  logic [7:0]    qmem [QBYTES];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;
  logic [AW-1:0] fptr, spec_addr, sel_addr;
  logic          spec_pend, room, xfer, wr, pop;
  logic [1:0]    wr_n;

  assign room      = count <= CW'(QBYTES - 2);
  assign mem_req   = spec_pend | room;
  assign sel_addr  = spec_pend ? spec_addr : fptr;
  assign mem_addr  = {sel_addr[AW-1:1], 1'b0};
  assign pop_valid = count != '0;
  assign pop_byte  = qmem[head];

  assign xfer = mem_req & mem_ack & ~flush;
  assign wr   = xfer & ~spec_pend;
  assign wr_n = !wr ? 2'd0 : (fptr[0] ? 2'd1 : 2'd2);
  assign pop  = pop_valid & pop_ready & ~flush;

  always_ff @(posedge clk) begin
    if (wr) begin
      if (fptr[0]) begin
        qmem[tail] <= mem_rdata[15:8];
      end else begin
        qmem[tail]           <= mem_rdata[7:0];
        qmem[tail + PW'(1)]  <= mem_rdata[15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      fptr      <= AW'(RESET_ADDR);
      spec_addr <= '0;
      spec_pend <= 1'b0;
    end else if (flush) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      fptr      <= flush_addr;
      spec_pend <= 1'b0;
    end else begin
      if (pop) head <= head + PW'(1);
      tail  <= tail + PW'(wr_n);
      fptr  <= fptr + AW'(wr_n);
      count <= count + CW'(wr_n) - CW'(pop);
      if (br_hint) begin
        spec_pend <= 1'b1;
        spec_addr <= br_target;
      end else if (xfer && spec_pend) begin
        spec_pend <= 1'b0;
      end
    end
  end
endmodule

module pfq_unit_chk #(
  parameter int AW     = 20,
  parameter int QBYTES = 16,
  parameter int CW     = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic          br_hint,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          pop_valid,
  input logic [CW-1:0] count,
  input logic          spec_pend
);
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(QBYTES));

  a_r2_room_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !spec_pend && !flush) |-> count <= CW'(QBYTES - 2));

  a_r6_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !flush && !br_hint) |=> (mem_req && $stable(mem_addr)));

  a_r7_spec_once: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spec_pend) && !$past(flush)) |-> $past(mem_req && mem_ack));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pop_valid);

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
endmodule

bind pfq_unit pfq_unit_chk #(.AW(AW), .QBYTES(QBYTES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .br_hint(br_hint),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .pop_valid(pop_valid), .count(count), .spec_pend(spec_pend)
);

// File: tb/test_pfq_unit.sv
module test_pfq_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        flush = 0, br_hint = 0, mem_ack = 0, pop_ready = 0;
  logic [19:0] flush_addr = 0, br_target = 0;
  logic        mem_req, pop_valid;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [7:0]  pop_byte;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h3C;
  endfunction

  assign mem_rdata = {mbyte({mem_addr[19:1], 1'b1}), mbyte({mem_addr[19:1], 1'b0})};

  pfq_unit i_pfq_unit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .br_hint(br_hint), .br_target(br_target), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pop_valid(pop_valid), .pop_byte(pop_byte), .pop_ready(pop_ready)
  );

  logic [7:0]  mq[$];
  logic [19:0] m_fptr = 20'hFFFF0, m_spec = 0;
  bit          m_pend = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_req();
    return m_pend || (mq.size() <= 14);
  endfunction

  function automatic logic [19:0] exp_addr();
    logic [19:0] a = m_pend ? m_spec : m_fptr;
    return {a[19:1], 1'b0};
  endfunction

  task automatic compare_all();
    chk(mem_req == exp_req(), m_pend ? "R7 mem_req" : "R2 mem_req", 32'(mem_req), 32'(exp_req()));
    if (exp_req())
      chk(mem_addr == exp_addr(), m_pend ? "R7 mem_addr" : "R2 mem_addr", 32'(mem_addr), 32'(exp_addr()));
    chk(pop_valid == (mq.size() != 0), "R5 pop_valid", 32'(pop_valid), 32'(mq.size() != 0));
    if (mq.size() != 0)
      chk(pop_byte == mq[0], "R3 pop_byte", 32'(pop_byte), 32'(mq[0]));
  endtask

  task automatic model_update();
    bit do_pop, do_xfer;
    if (flush) begin
      mq.delete();
      m_fptr = flush_addr;
      m_pend = 0;
      return;
    end
    do_pop  = pop_ready && mq.size() != 0;
    do_xfer = exp_req() && mem_ack;
    if (do_pop) void'(mq.pop_front());
    if (do_xfer) begin
      if (m_pend) m_pend = 0;
      else if (m_fptr[0]) begin
        mq.push_back(mbyte(m_fptr));
        m_fptr = m_fptr + 1;
      end else begin
        mq.push_back(mbyte(m_fptr));
        mq.push_back(mbyte(m_fptr + 1));
        m_fptr = m_fptr + 2;
      end
    end
    if (br_hint) begin
      m_pend = 1;
      m_spec = br_target;
    end
  endtask

  task automatic step(input bit fl, input logic [19:0] fa, input bit hi,
                      input logic [19:0] ta, input bit ak, input bit rd);
    @(negedge clk);
    compare_all();
    flush = fl; flush_addr = fa; br_hint = hi; br_target = ta;
    mem_ack = ak; pop_ready = rd;
    @(posedge clk);
    model_update();
    #1;
  endtask

  initial begin
    logic [19:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pop_valid == 0, "R1 pop_valid", 32'(pop_valid), 0);
    chk(mem_req == 1, "R1 mem_req", 32'(mem_req), 1);
    chk(mem_addr == 20'hFFFF0, "R1 mem_addr", 32'(mem_addr), 32'hFFFF0);
    rst_n = 1;
    @(posedge clk); #1;
    chk(mem_addr == 20'hFFFF0 && pop_valid == 0, "R1 after release", 32'(mem_addr), 32'hFFFF0);

    repeat (10) step(0, 0, 0, 0, 1, 0);
    chk(mem_req == 0, "R10 full no request", 32'(mem_req), 0);
    chk(pop_valid == 1, "R10 full valid", 32'(pop_valid), 1);

    step(0, 0, 1, 20'h0ABC7, 0, 0);
    chk(mem_req == 1 && mem_addr == 20'h0ABC6, "R7 target while full", 32'(mem_addr), 32'h0ABC6);
    step(0, 0, 0, 0, 1, 0);
    chk(mem_req == 0, "R7 data dropped", 32'(mem_req), 0);

    repeat (20) step(0, 0, 0, 0, 0, 1);
    chk(pop_valid == 0, "R5 empty stall", 32'(pop_valid), 0);

    held = mem_addr;
    repeat (3) step(0, 0, 0, 0, 0, 0);
    chk(mem_req == 1 && mem_addr == held, "R6 held request", 32'(mem_addr), 32'(held));

    step(1, 20'h12345, 0, 0, 0, 0);
    chk(pop_valid == 0, "R9 flush empty", 32'(pop_valid), 0);
    chk(mem_addr == 20'h12344, "R9 flush addr", 32'(mem_addr), 32'h12344);
    step(0, 0, 0, 0, 1, 0);
    chk(pop_valid == 1 && pop_byte == mbyte(20'h12345), "R4 odd upper byte", 32'(pop_byte), 32'(mbyte(20'h12345)));
    chk(mem_addr == 20'h12346, "R4 realigned", 32'(mem_addr), 32'h12346);

    step(0, 0, 1, 20'h30000, 0, 0);
    step(0, 0, 1, 20'h40001, 0, 0);
    chk(mem_addr == 20'h40000, "R8 replaced target", 32'(mem_addr), 32'h40000);
    step(0, 0, 0, 0, 1, 0);
    chk(mem_addr == 20'h12346, "R8 single target fetch", 32'(mem_addr), 32'h12346);

    step(1, 20'h50000, 1, 20'h60000, 1, 1);
    chk(mem_addr == 20'h50000 && pop_valid == 0, "R9 flush beats hint", 32'(mem_addr), 32'h50000);

    for (int i = 0; i < 3000; i++) begin
      bit fl = ($urandom_range(99) < 2);
      bit hi = ($urandom_range(99) < 5);
      step(fl, 20'($urandom), hi, 20'($urandom), $urandom_range(99) < 60, $urandom_range(99) < 50);
    end
    repeat (30) step(0, 0, 0, 0, 1, 0);
    chk(mem_req == 0 && pop_valid == 1, "R10 refill to full", 32'(mem_req), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule